// File: doc/BRIEF.md
# Two-Channel Burst PWM Generator

This block drives two independent pulse-width-modulated outputs. Each channel holds its own high time, low time and burst length. The high and low times are counted in base ticks, and one base tick is 100 µs. A prescaler derives the base tick from the system clock. A command processor configures the block by presenting one code byte and a 16-bit parameter for a single clock cycle. Most codes load one channel register. One code writes a shared enable mask that starts and stops both channels.

A channel whose enable bit is set emits high/low cycles. A burst length of zero makes it run without end. A nonzero burst length N makes it emit exactly N high pulses and then park low. When the burst ends, the channel clears its own enable bit, so the host can see that the burst is complete. The host must clear a channel's enable bit before it reprograms that channel, and then set the bit again to start it.

Top module: `pwm2_burst`

## Requirements
- R1: After reset both outputs are low, the enable mask is 0, both high and low times are 1 tick, and both burst lengths are 0.
- R2: Command codes for channel c are: high time 0x10+2c, low time 0x11+2c, burst length 0x14+c. Each takes the full 16-bit parameter.
- R3: Code 0x1F loads the enable mask from parameter bits [1:0], where bit c enables channel c. Higher parameter bits have no effect.
- R4: In the cycle after its enable bit is written from 0 to 1, a channel's output is high (the high phase comes first).
- R5: Every high phase after the first lasts (high time × TICK_DIV) clock cycles, and every low phase lasts (low time × TICK_DIV) clock cycles. The first high phase lasts between 1 and (high time × TICK_DIV) cycles, because the base tick runs freely.
- R6: With a burst length N > 0, the channel emits exactly N high pulses. At the end of the N-th low phase its enable bit clears by itself and the output stays low.
- R7: With a burst length of 0, the channel keeps its enable bit and keeps emitting pulses without limit. The other channel runs independently while it does.
- R8: When a channel's enable bit is written to 0, its output is low in the next cycle.
- R9: A high or low time written as 0 is stored and timed as 1 tick.
- R10: Codes other than those in R2 and R3 (for example 0x00, 0x16 and 0x1E) change neither the enable mask nor any channel setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| cmd_param | input | 16 | Command parameter |
| en_mask | output | 2 | Current channel enable bits |
| pwm_out | output | 2 | PWM outputs, bit c for channel c |

## Verification
Directed runs and random runs drive bursts with short, unequal high and low times. Because the times are unequal, a swap of the two phases or a per-channel code decode that is off by one shows up as a wrong phase length. Burst lengths of 1 and of several pulses separate a wrong count of pulses from a missing self-clear of the enable bit. A continuous run on one channel during a burst on the other exposes any coupling between the channels. Writes with a zero period, writes of unused codes, and mask writes with high bits set are each followed by a timed burst, so the bench can show what the stored configuration actually is.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int NCH = 2;
  localparam int PW  = 16;

  typedef enum logic {PH_HI = 1'b0, PH_LO = 1'b1} phase_e;

  localparam logic [7:0] CODE_MASK = 8'h1F;

  function automatic logic [7:0] hi_code(input int c);
    return 8'h10 + 8'(2 * c);
  endfunction

  function automatic logic [7:0] lo_code(input int c);
    return 8'h11 + 8'(2 * c);
  endfunction

  function automatic logic [7:0] burst_code(input int c);
    return 8'h14 + 8'(c);
  endfunction

  // a zero period is timed as one tick
  function automatic logic [PW-1:0] clamp_period(input logic [PW-1:0] p);
    return (p == '0) ? PW'(1) : p;
  endfunction

  function automatic logic is_known(input logic [7:0] code);
    logic k;
    k = (code == CODE_MASK);
    for (int c = 0; c < NCH; c++)
      k = k | (code == hi_code(c)) | (code == lo_code(c)) | (code == burst_code(c));
    return k;
  endfunction
endpackage

// File: rtl/pwm2_tick.sv
module pwm2_tick #(
  parameter int DIV = 5000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      assign tick = (cnt == CW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/pwm2_cfg.sv
module pwm2_cfg
  import pwm2_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [7:0]              cmd_code,
  input  logic [PW-1:0]           cmd_param,
  input  logic [NCH-1:0]          done,
  output logic [NCH-1:0][PW-1:0]  hi_per,
  output logic [NCH-1:0][PW-1:0]  lo_per,
  output logic [NCH-1:0][PW-1:0]  burst,
  output logic [NCH-1:0]          en_mask
);
  logic mask_wr;
  assign mask_wr = cmd_valid && (cmd_code == CODE_MASK);

  // a command write wins over a self-clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)       en_mask <= '0;
    else if (mask_wr) en_mask <= cmd_param[NCH-1:0];
    else              en_mask <= en_mask & ~done;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_per[c] <= PW'(1);
        lo_per[c] <= PW'(1);
        burst[c]  <= '0;
      end else if (cmd_valid) begin
        if (cmd_code == hi_code(c))    hi_per[c] <= clamp_period(cmd_param);
        if (cmd_code == lo_code(c))    lo_per[c] <= clamp_period(cmd_param);
        if (cmd_code == burst_code(c)) burst[c]  <= cmd_param;
      end
    end
  end
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan
  import pwm2_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic [PW-1:0] hi_per,
  input  logic [PW-1:0] lo_per,
  input  logic [PW-1:0] burst,
  output logic          pwm,
  output logic          done
);
  phase_e        phase;
  logic [PW-1:0] cnt;
  logic [PW-1:0] left;
  logic          phase_end;

  assign phase_end = en && tick && (cnt <= PW'(1));
  assign done      = phase_end && (phase == PH_LO) && (left == PW'(1));
  assign pwm       = en && (phase == PH_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_HI;
      cnt   <= PW'(1);
      left  <= '0;
    end else if (!en) begin
      // parked: keep the start state loaded from the current settings
      phase <= PH_HI;
      cnt   <= hi_per;
      left  <= burst;
    end else if (tick) begin
      if (!phase_end) begin
        cnt <= cnt - PW'(1);
      end else if (phase == PH_HI) begin
        phase <= PH_LO;
        cnt   <= lo_per;
      end else begin
        phase <= PH_HI;
        cnt   <= hi_per;
        if (left != '0) left <= left - PW'(1);
      end
    end
  end
endmodule

// File: rtl/pwm2_burst.sv
module pwm2_burst #(
  parameter int TICK_DIV = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_code,
  input  logic [15:0] cmd_param,
  output logic [1:0]  en_mask,
  output logic [1:0]  pwm_out
);
  import pwm2_pkg::*;

  logic                   tick;
  logic [NCH-1:0]         done;
  logic [NCH-1:0][PW-1:0] hi_per;
  logic [NCH-1:0][PW-1:0] lo_per;
  logic [NCH-1:0][PW-1:0] burst;

  pwm2_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pwm2_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_param(cmd_param), .done(done), .hi_per(hi_per), .lo_per(lo_per),
    .burst(burst), .en_mask(en_mask)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm2_chan u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_mask[c]),
      .hi_per(hi_per[c]), .lo_per(lo_per[c]), .burst(burst[c]),
      .pwm(pwm_out[c]), .done(done[c])
    );
  end
endmodule

// File: rtl/pwm2_burst_chk.sv
module pwm2_burst_chk
  import pwm2_pkg::*;
#(
  parameter int TICK_DIV = 5000
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [7:0]             cmd_code,
  input logic [1:0]             en_mask,
  input logic [1:0]             pwm_out,
  input logic                   tick,
  input logic [NCH-1:0]         done,
  input logic [NCH-1:0][PW-1:0] hi_per,
  input logic [NCH-1:0][PW-1:0] lo_per
);
  logic mask_wr;
  assign mask_wr = cmd_valid && (cmd_code == CODE_MASK);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en_mask[c] |-> !pwm_out[c]);

    a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_mask[c]) |-> pwm_out[c]);

    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (done[c] && !mask_wr) |=> !en_mask[c]);

    a_r9_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_per[c] != '0) && (lo_per[c] != '0));

    // R5: while running, the output only moves on a base tick
    a_r5_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mask[c] && $past(en_mask[c]) && (pwm_out[c] != $past(pwm_out[c])))
        |-> $past(tick));
  end

  a_r10_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_known(cmd_code) && (done == '0)) |=> $stable(en_mask));

  if (TICK_DIV > 1) begin : g_sp
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end
endmodule

bind pwm2_burst pwm2_burst_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .en_mask(en_mask), .pwm_out(pwm_out), .tick(tick), .done(done),
  .hi_per(hi_per), .lo_per(lo_per)
);

// File: tb/pwm2_burst_test.sv
module pwm2_burst_test;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [15:0] cmd_param = '0;
  logic [1:0]  en_mask;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [1:0] mask_sh = '0;

  always #10 clk = ~clk;

  pwm2_burst #(.TICK_DIV(D)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_param(cmd_param), .en_mask(en_mask), .pwm_out(pwm_out)
  );

  function automatic int exp_len(input int p);
    return ((p == 0) ? 1 : p) * D;
  endfunction

  function automatic logic [7:0] code_of(input int kind, input int c);
    case (kind)
      0:       return 8'(16 + 2 * c);
      1:       return 8'(17 + 2 * c);
      default: return 8'(20 + c);
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] code, input logic [15:0] prm);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_param = prm;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_mask(input logic [1:0] m);
    mask_sh = m;
    send(8'h1F, {14'h3FFC, m});  // upper bits set on purpose (R3)
  endtask

  // programs (optionally) and runs one burst on channel c, then times it
  task automatic run_burst(input int c, input bit cfg, input int hw, input int lw,
                           input int n, input int he, input int le);
    int plen; int pulses; bit prev; bit first; int limit; bit ok;
    if (cfg) begin
      set_mask(mask_sh & ~(2'b01 << c));
      send(code_of(0, c), 16'(hw));
      send(code_of(1, c), 16'(lw));
      send(code_of(2, c), 16'(n));
    end
    set_mask(mask_sh | (2'b01 << c));
    check("R4 start high", int'(pwm_out[c]), 1);
    prev = 1'b1; first = 1'b1; plen = 1; pulses = 1; ok = 1'b0;
    limit = (n * (he + le) + 4) * D + 8;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!en_mask[c]) begin
        check("R6 ends after low phase", int'(prev), 0);
        check("R5 last low length", plen, le * D);
        check("R6 pulse count", pulses, n);
        check("R6 output parked low", int'(pwm_out[c]), 0);
        ok = 1'b1;
        break;
      end
      if (pwm_out[c] != prev) begin
        if (prev && first) begin
          check("R5 first high within bound", int'(plen >= 1 && plen <= he * D), 1);
          first = 1'b0;
        end else if (prev) begin
          check("R5 high length", plen, he * D);
        end else begin
          check("R5 low length", plen, le * D);
          pulses++;
        end
        prev = pwm_out[c];
        plen = 1;
      end else begin
        plen++;
      end
    end
    if (!ok) check("R6 enable self-clear seen", 0, 1);
    mask_sh = en_mask;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    if (!finished) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rises;
    bit last;
    void'($urandom(32'h5EED_1A2B));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 mask after reset", int'(en_mask), 0);
    check("R1 outputs after reset", int'(pwm_out), 0);
    // R1: default periods 1/1 and burst 0 => continuous 1-tick pulses
    set_mask(2'b01);
    repeat (3 * D) @(negedge clk);
    check("R1 default burst is continuous", int'(en_mask[0]), 1);
    set_mask(2'b00);
    check("R8 off after disable", int'(pwm_out[0]), 0);

    // R2 per-channel codes, unequal times
    run_burst(0, 1, 2, 3, 2, 2, 3);
    run_burst(1, 1, 3, 1, 3, 3, 1);
    run_burst(0, 1, 1, 1, 1, 1, 1);

    // R10: unused codes leave settings and mask unchanged
    send(8'h16, 16'h0001);
    send(8'h00, 16'h0005);
    send(8'h1E, 16'h0003);
    check("R10 mask unchanged", int'(en_mask), 0);
    check("R10 outputs unchanged", int'(pwm_out), 0);
    run_burst(0, 0, 1, 1, 1, 1, 1);

    // R9: zero period is timed as one tick
    run_burst(1, 1, 0, 0, 2, 1, 1);

    // R3: mask write, upper bits ignored
    send(8'h1F, 16'hFFFE);
    @(negedge clk);
    check("R3 mask from low bits", int'(en_mask), 2);
    send(8'h1F, 16'h0000);
    mask_sh = 2'b00;

    // R8: disable mid high phase
    send(8'h10, 16'd6);
    send(8'h14, 16'd0);
    set_mask(2'b01);
    @(negedge clk);
    check("R8 high before disable", int'(pwm_out[0]), 1);
    set_mask(2'b00);
    check("R8 low right after disable", int'(pwm_out[0]), 0);

    // R7: channel 1 continuous while channel 0 bursts
    send(8'h12, 16'd1);
    send(8'h13, 16'd2);
    send(8'h15, 16'd0);
    set_mask(2'b10);
    run_burst(0, 1, 2, 1, 3, 2, 1);
    check("R7 continuous channel still enabled", int'(en_mask[1]), 1);
    rises = 0; last = pwm_out[1];
    for (int i = 0; i < 12 * D; i++) begin
      @(negedge clk);
      if (pwm_out[1] && !last) rises++;
      last = pwm_out[1];
    end
    check("R7 continuous pulses", rises, 4);
    set_mask(2'b00);

    // random bursts
    for (int k = 0; k < 10; k++) begin
      int c; int h; int l; int n;
      c = int'($urandom_range(1, 0));
      h = int'($urandom_range(5, 1));
      l = int'($urandom_range(5, 1));
      n = int'($urandom_range(4, 1));
      run_burst(c, 1, h, l, n, h, l);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule